// File: doc/BRIEF.md
# Programmable Bit-Rate Tick Generator

This block produces the bit-rate timing reference for a single-wire host controller. It divides a reference clock in three cascaded stages. The first is a fixed divide-by-four. The second is a linear stage of length 4·m+1, where m is an 8-bit timing value. The third is a power-of-two stage of length 2^e, where e is a 3-bit exponent. The overall period is 4 × (4·m+1) × 2^e reference cycles. The result is not a derived clock. It is a one-cycle enable pulse in the reference domain, which the bus logic uses to qualify its own registers.

Configuration registers supply the timing value, the exponent and a run bit. The block keeps a registered copy of the settings in use and reports it on its outputs. While the run bit is low, that copy follows the inputs and all stage counters sit at zero. While running, a new setting is adopted only at the end of a full period, so a partial (runt) period is never produced. A timing value of zero is handled as one.

Top module: `bdiv_tick_gen`

## Requirements
- R1: After reset, `tick` is 0, `act_timing` is 1 and `act_exp` is 0.
- R2: While `run` is high, consecutive `tick` pulses are spaced exactly 4 × (4·m+1) × 2^e reference cycles apart, with m = `act_timing` and e = `act_exp`.
- R3: `tick` is never high for two consecutive cycles.
- R4: When `run` is first sampled high at clock edge k, the first `tick` is high in the cycle after edge k+P−1, P cycles after the start, where P is the period given in R2.
- R5: While `run` is low, `tick` stays 0 and the active settings follow `timing_val`/`div_exp` with a one-cycle delay.
- R6: A `timing_val` of 0 is handled as 1: `act_timing` reads 1 and the period is 4 × 5 × 2^e.
- R7: While running, a change of `timing_val` or `div_exp` does not alter the period in progress. The active settings update on the same edge that raises `tick`, and the following period uses the new ratio.
- R8: Lowering `run` partway through a period clears the stage counters, so a later restart again gives its first tick P cycles after `run` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Divider enable from configuration |
| timing_val | input | 8 | Linear stage setting m (0 handled as 1) |
| div_exp | input | 3 | Power-of-two exponent e |
| tick | output | 1 | One-cycle pulse at the divided rate |
| act_timing | output | 8 | Timing value currently in use |
| act_exp | output | 3 | Exponent currently in use |

## Verification
If a stage counter's state goes wrong, the very next period comes out with the wrong length. Measuring tick-to-tick gaps therefore exposes such a fault within one period, and latency from enable exposes a counter that was not cleared. Errors in when the settings are adopted show up on the active-setting outputs at the tick edge, and as one period of the wrong length straight after a reconfiguration. The bench sweeps every small m and e combination, plus the two extremes of each field.

// File: rtl/bdiv_pkg.sv
package bdiv_pkg;
    localparam int TIME_W   = 8;
    localparam int EXP_W    = 3;
    localparam int FIX_DIV  = 4;
    localparam int LIN_STEP = 4;
    localparam int FIX_W    = $clog2(FIX_DIV);
    localparam int LIN_W    = TIME_W + $clog2(LIN_STEP);
    localparam int POW_W    = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [TIME_W-1:0] m;
        logic [EXP_W-1:0]  e;
    } bdiv_cfg_t;

    localparam bdiv_cfg_t CFG_RESET = '{m: TIME_W'(1), e: '0};

    function automatic bdiv_cfg_t clean_cfg(input logic [TIME_W-1:0] m,
                                            input logic [EXP_W-1:0]  e);
        bdiv_cfg_t c;
        c.m = (m == '0) ? TIME_W'(1) : m;
        c.e = e;
        return c;
    endfunction

    function automatic logic [LIN_W-1:0] lin_last(input logic [TIME_W-1:0] m);
        return LIN_W'(LIN_STEP) * LIN_W'(m);
    endfunction

    function automatic logic [POW_W-1:0] pow_last(input logic [EXP_W-1:0] e);
        return POW_W'((32'd1 << e) - 32'd1);
    endfunction
endpackage

// File: rtl/bdiv_stage.sv
module bdiv_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic         at_last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold)
            cnt <= '0;
        else if (adv)
            cnt <= (cnt == last) ? '0 : cnt + W'(1);
    end

    assign at_last = (cnt == last);

    // R2: a stage never runs past its terminal value
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= last);
endmodule

// File: rtl/bdiv_cfg_hold.sv
module bdiv_cfg_hold
    import bdiv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  bdiv_cfg_t cfg_in,
    output bdiv_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (load)
            cfg_q <= cfg_in;
    end

    // R6: the stored timing value is never zero
    a_r6_nonzero_timing: assert property (@(posedge clk) disable iff (rst)
        cfg_q.m != '0);
endmodule

// File: rtl/bdiv_tick_gen.sv
module bdiv_tick_gen
    import bdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [TIME_W-1:0] timing_val,
    input  logic [EXP_W-1:0]  div_exp,
    output logic              tick,
    output logic [TIME_W-1:0] act_timing,
    output logic [EXP_W-1:0]  act_exp
);
    bdiv_cfg_t cfg_now;
    logic      fix_last, lin_end, pow_end;
    logic      adv_lin, adv_pow, wrap;
    logic      tick_q;

    assign adv_lin = run && fix_last;
    assign adv_pow = adv_lin && lin_end;
    assign wrap    = adv_pow && pow_end;

    bdiv_cfg_hold u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (!run || wrap),
        .cfg_in (clean_cfg(timing_val, div_exp)),
        .cfg_q  (cfg_now)
    );

    bdiv_stage #(.W(FIX_W)) u_fix (
        .clk     (clk),
        .rst     (rst),
        .hold    (!run),
        .adv     (run),
        .last    (FIX_W'(FIX_DIV - 1)),
        .at_last (fix_last)
    );

    bdiv_stage #(.W(LIN_W)) u_lin (
        .clk     (clk),
        .rst     (rst),
        .hold    (!run),
        .adv     (adv_lin),
        .last    (lin_last(cfg_now.m)),
        .at_last (lin_end)
    );

    bdiv_stage #(.W(POW_W)) u_pow (
        .clk     (clk),
        .rst     (rst),
        .hold    (!run),
        .adv     (adv_pow),
        .last    (pow_last(cfg_now.e)),
        .at_last (pow_end)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tick_q <= 1'b0;
        else
            tick_q <= wrap;
    end

    assign tick       = tick_q;
    assign act_timing = cfg_now.m;
    assign act_exp    = cfg_now.e;

    // R3: the pulse is one cycle wide
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: no pulse follows a cycle with the divider stopped
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

    // R7: settings in use hold steady inside a running period
    a_r7_settings_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(cfg_now));
endmodule

// File: tb/bdiv_tick_gen_bench.sv
module bdiv_tick_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] timing_val = 8'd0;
    logic [2:0] div_exp = 3'd0;
    logic       tick;
    logic [7:0] act_timing;
    logic [2:0] act_exp;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit wd_hit = 0;

    always #10 clk = ~clk;

    bdiv_tick_gen u_bdiv_tick_gen (
        .clk(clk), .rst(rst), .run(run), .timing_val(timing_val),
        .div_exp(div_exp), .tick(tick), .act_timing(act_timing), .act_exp(act_exp)
    );

    function automatic int period(input int m, input int e);
        int mm = (m == 0) ? 1 : m;
        return 4 * (4 * mm + 1) * (1 << e);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !wd_hit) begin
            wd_hit = 1;
            chk(0, "watchdog", cyc, 190000);
            finish_run();
        end
    end

    // counts negedges until tick is seen; returns the count
    task automatic cycles_to_tick(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            if (tick) return;
        end
        n = -1;
    endtask

    task automatic stop_and_set(input int m, input int e);
        run = 1'b0;
        timing_val = 8'(m);
        div_exp = 3'(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int n, p;
        repeat (3) @(negedge clk);
        // R1
        chk(tick == 1'b0, "R1 tick", tick, 0);
        chk(act_timing == 8'd1, "R1 act_timing", act_timing, 1);
        chk(act_exp == 3'd0, "R1 act_exp", act_exp, 0);
        rst = 1'b0;
        @(negedge clk);

        // R5: stopped, settings follow, no tick
        stop_and_set(5, 2);
        chk(act_timing == 8'd5, "R5 act_timing follows", act_timing, 5);
        chk(act_exp == 3'd2, "R5 act_exp follows", act_exp, 2);
        begin
            int seen = 0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (tick) seen++;
            end
            chk(seen == 0, "R5 no tick while stopped", seen, 0);
        end

        // R2 R3 R4 R6: sweep small configurations
        for (int m = 0; m < 4; m++) begin
            for (int e = 0; e < 3; e++) begin
                stop_and_set(m, e);
                p = period(m, e);
                if (m == 0)
                    chk(act_timing == 8'd1, "R6 zero handled as one", act_timing, 1);
                run = 1'b1;
                cycles_to_tick(p + 10, n);
                chk(n == p, "R4 first tick latency", n, p);
                @(negedge clk);
                chk(tick == 1'b0, "R3 pulse width", tick, 0);
                cycles_to_tick(p + 10, n);
                chk(n == p - 1, "R2 period", n + 1, p);
            end
        end

        // R2 extremes
        stop_and_set(255, 0);
        p = period(255, 0);
        run = 1'b1;
        cycles_to_tick(p + 10, n);
        chk(n == p, "R4 latency m=255", n, p);
        cycles_to_tick(p + 10, n);
        chk(n == p, "R2 period m=255", n, p);
        stop_and_set(1, 7);
        p = period(1, 7);
        run = 1'b1;
        cycles_to_tick(p + 10, n);
        chk(n == p, "R4 latency e=7", n, p);
        cycles_to_tick(p + 10, n);
        chk(n == p, "R2 period e=7", n, p);

        // R7: reconfigure mid-period
        stop_and_set(1, 0);
        run = 1'b1;
        cycles_to_tick(100, n);
        repeat (5) @(negedge clk);
        timing_val = 8'd2;
        div_exp = 3'd1;
        @(negedge clk);
        chk(act_timing == 8'd1, "R7 no early update", act_timing, 1);
        cycles_to_tick(100, n);
        chk(n == 20 - 6, "R7 current period kept", n + 6, 20);
        chk(act_timing == 8'd2, "R7 update at tick m", act_timing, 2);
        chk(act_exp == 3'd1, "R7 update at tick e", act_exp, 1);
        cycles_to_tick(200, n);
        chk(n == period(2, 1), "R7 new period", n, period(2, 1));

        // R8: stop mid-period, restart
        repeat (30) @(negedge clk);
        run = 1'b0;
        repeat (3) @(negedge clk);
        chk(tick == 1'b0, "R8 idle", tick, 0);
        run = 1'b1;
        p = period(2, 1);
        cycles_to_tick(p + 10, n);
        chk(n == p, "R8 restart latency", n, p);

        finish_run();
    end
endmodule